// File: doc/BRIEF.md
# Deterministic Pin Replicator

This block carries a group of general-purpose input pins across a serial link and drives them out on the far side after a fixed delay. The delay is known at design time. On the sending side a sampler captures the pins once every `DECIM` clock cycles. Each capture leaves as a link word with a valid flag. On the receiving side only valid words enter a small elastic FIFO.

A release timer pops one entry every `DECIM` cycles. The first pop happens `LATENCY` cycles after the first capture. The receiver therefore waits a fixed time before it drives anything. Any arrival delay from 0 to `LATENCY-2` cycles is absorbed, so the output delay does not depend on link jitter. Capturing at the reduced rate adds up to one sample period of timing uncertainty on the pins themselves.

Both directions live in one clock domain. The link between `tx_*` and `rx_*` is external: a transport, or in simulation a delay model. If the FIFO is empty at a release, the output keeps its previous value and a sticky underflow flag is set. If a word arrives while the FIFO is full and no release is happening in that cycle, the word is dropped and a sticky overflow flag is set.

Top module: `pinrep_top`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `pins_out` becomes all-zero and `underflow`, `overflow` and `tx_valid` become 0.
- R2: Clock edges after reset release are numbered 0, 1, 2, … from the first edge with `rst_n` high. At edges 0, `DECIM`, 2·`DECIM`, … the sampler raises `tx_valid` for exactly one cycle, and `tx_data` carries the value `pins_in` had at that edge.
- R3: `pins_out` can change only at release edges `LATENCY + m·DECIM` (m ≥ 0). Before edge `LATENCY` it stays all-zero.
- R4: After release edge r, `pins_out` equals `pins_in` as captured at edge r − `LATENCY`. This holds for any arrival delay of 0 to `LATENCY-2` cycles between `tx_valid` and `rx_valid`, including a delay that changes from one word to the next without reordering.
- R5: A cycle with `rx_valid` = 0 writes nothing, whatever `rx_data` holds.
- R6: At a release edge with the FIFO empty, `pins_out` keeps its previous value and `underflow` goes to 1. It stays 1 until reset.
- R7: A valid word that arrives while the FIFO holds `DEPTH` entries and no release occurs in that cycle is dropped. `overflow` then goes to 1 and stays 1 until reset.
- R8: A valid word that arrives while the FIFO is full, in the same cycle as a release, is accepted.
- R9: Words leave the FIFO in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by sampler and receiver |
| rst_n | input | 1 | Synchronous reset, active low |
| pins_in | input | PINS | Pins to be replicated |
| tx_valid | output | 1 | Link word valid, one cycle per sample period |
| tx_data | output | PINS | Captured pin values |
| rx_valid | input | 1 | Arriving link word is valid |
| rx_data | input | PINS | Arriving pin values |
| pins_out | output | PINS | Replicated pins, delayed by LATENCY |
| underflow | output | 1 | Sticky: a release found the FIFO empty |
| overflow | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
Two events can fall on the same edge: a write into the FIFO and a release from it. This matters in two corner states.

In the first, the FIFO is full. The bench keeps `rx_valid` high continuously from edge 0 through edge 20 while the first release fires at edge 20. The word written at edge 20 must appear as the ninth output, after the eight words accepted earlier, while the words sent at edges 8 to 19 are lost.

In the second, the FIFO is empty. The bench sets the link delay to `LATENCY-1`, so the first word lands on the first release edge. That release must count as an underflow and hold zero, and the captured value must appear one sample period later.

// File: rtl/pinrep_pkg.sv
// Shared definitions for the pin replicator.
// Assumes a single clock for the sending and receiving halves.
package pinrep_pkg;

    // Sticky error flags reported by the receiving half.
    typedef struct packed {
        logic underflow;
        logic overflow;
    } pinrep_flags_t;

endpackage

// File: rtl/pinrep_sampler.sv
// Down-sampling pin capture.
// Captures pins_in once every DECIM cycles and emits a one-cycle valid word.
// Assumes DECIM >= 1; DECIM == 1 captures on every edge.
module pinrep_sampler #(
    parameter int PINS  = 8,
    parameter int DECIM = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins_in,
    output logic            tx_valid,
    output logic [PINS-1:0] tx_data
);
    logic take;

    generate
        if (DECIM > 1) begin : g_div
            localparam int DW = $clog2(DECIM);
            localparam logic [DW-1:0] LAST = DW'(DECIM - 1);
            logic [DW-1:0] phase;

            // Phase counter: zero marks a capture edge.
            always_ff @(posedge clk) begin
                if (!rst_n)             phase <= '0;
                else if (phase == LAST) phase <= '0;
                else                    phase <= phase + 1'b1;
            end
            assign take = (phase == '0);
        end else begin : g_full
            assign take = 1'b1;
        end
    endgenerate

    // Capture register: the link word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= take;
            if (take) tx_data <= pins_in;
        end
    end
endmodule

// File: rtl/pinrep_fifo.sv
// Elastic buffer for received samples.
// Push is accepted when not full, or when a pop happens in the same cycle.
// A push that is refused raises drop for one cycle.
// Assumes DEPTH is a power of two, at least 2.
module pinrep_fifo #(
    parameter int PINS  = 8,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PINS-1:0] wdata,
    input  logic            pop,
    output logic [PINS-1:0] head,
    output logic            empty,
    output logic            full,
    output logic            drop
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULLCNT = (AW+1)'(DEPTH);

    logic [PINS-1:0] mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [AW:0]     count;
    logic            do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULLCNT);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign head    = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pinrep_release_timer.sv
// Release schedule generator.
// Fires first LATENCY edges after reset release, then once every DECIM edges.
// Assumes LATENCY >= DECIM >= 1.
module pinrep_release_timer #(
    parameter int DECIM   = 4,
    parameter int LATENCY = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic fire
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] TOP    = CW'(LATENCY);
    localparam logic [CW-1:0] RELOAD = CW'(LATENCY - DECIM + 1);

    logic [CW-1:0] cnt;

    assign fire = (cnt == TOP);

    // Counts up to TOP, then reloads so that the next fire is DECIM edges later.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (fire) cnt <= RELOAD;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pinrep_top.sv
// Deterministic pin replicator: sampler, receive FIFO, release timer and
// output register. Sending and receiving halves share one clock. The
// external link must deliver each word within LATENCY-2 cycles and keep order.
module pinrep_top #(
    parameter int PINS    = 8,
    parameter int DECIM   = 4,
    parameter int LATENCY = 20,
    parameter int DEPTH   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins_in,
    output logic            tx_valid,
    output logic [PINS-1:0] tx_data,
    input  logic            rx_valid,
    input  logic [PINS-1:0] rx_data,
    output logic [PINS-1:0] pins_out,
    output logic            underflow,
    output logic            overflow
);
    import pinrep_pkg::*;

    logic            rel_fire;
    logic            fifo_empty, fifo_full, fifo_drop;
    logic [PINS-1:0] fifo_head;
    pinrep_flags_t   flags;

    pinrep_sampler #(.PINS(PINS), .DECIM(DECIM)) u_sampler (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    pinrep_fifo #(.PINS(PINS), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_valid), .wdata(rx_data), .pop(rel_fire),
        .head(fifo_head), .empty(fifo_empty), .full(fifo_full),
        .drop(fifo_drop)
    );

    pinrep_release_timer #(.DECIM(DECIM), .LATENCY(LATENCY)) u_timer (
        .clk(clk), .rst_n(rst_n), .fire(rel_fire)
    );

    // Output register: loads the FIFO head on a release, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pins_out <= '0;
        else if (rel_fire && !fifo_empty) pins_out <= fifo_head;
    end

    // Sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (rel_fire && fifo_empty) flags.underflow <= 1'b1;
            if (fifo_drop)              flags.overflow  <= 1'b1;
        end
    end

    assign underflow = flags.underflow;
    assign overflow  = flags.overflow;
endmodule

// File: rtl/pinrep_checker.sv
// Temporal checks for pinrep_top, attached by bind.
module pinrep_checker #(
    parameter int PINS  = 8,
    parameter int DECIM = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tx_valid,
    input logic            rx_valid,
    input logic [PINS-1:0] pins_out,
    input logic            underflow,
    input logic            overflow,
    input logic            rel_fire,
    input logic            fifo_empty,
    input logic            fifo_full
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pins_out == '0 && !underflow && !overflow && !tx_valid));

    generate
        if (DECIM > 1) begin : g_spacing
            a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                tx_valid |=> !tx_valid);
        end
    endgenerate

    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_fire |=> $stable(pins_out));

    a_r6_hold_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_fire && fifo_empty) |=> ($stable(pins_out) && underflow));

    a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fifo_full && !rel_fire) |=> (overflow && fifo_full));

    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r8_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fifo_full && rel_fire) |=> fifo_full);
endmodule

bind pinrep_top pinrep_checker #(.PINS(PINS), .DECIM(DECIM)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .rx_valid(rx_valid),
    .pins_out(pins_out), .underflow(underflow), .overflow(overflow),
    .rel_fire(rel_fire), .fifo_empty(fifo_empty), .fifo_full(fifo_full)
);

// File: tb/sim_pinrep_top.sv
// Directed bench for pinrep_top with a delay model of the link.
module sim_pinrep_top;
    localparam int  PINS    = 8;
    localparam int  DECIM   = 4;
    localparam int  LATENCY = 20;
    localparam int  DEPTH   = 8;
    localparam time TCLK    = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PINS-1:0] pins_in = '0;
    logic            tx_valid;
    logic [PINS-1:0] tx_data;
    logic            rx_valid = 1'b0;
    logic [PINS-1:0] rx_data = '0;
    logic [PINS-1:0] pins_out;
    logic            underflow, overflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int k;                          // edges seen since reset release

    logic [PINS-1:0] hist [0:1023];
    logic            slot_v [0:63];
    logic [PINS-1:0] slot_d [0:63];

    pinrep_top #(.PINS(PINS), .DECIM(DECIM), .LATENCY(LATENCY), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .pins_out(pins_out), .underflow(underflow), .overflow(overflow)
    );

    always #(TCLK/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at edge %0d: actual %0h expected %0h", req, k, act, exp);
        end
    endtask

    // Reset for a few cycles; release at a falling edge so edge 0 follows.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0;
        for (int i = 0; i < 64; i++) slot_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        k = 0;
    endtask

    // R1: state right after reset, before edge 0.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pins_in = 8'hA5; rx_valid = 1'b1; rx_data = 8'h3C;
        repeat (2) @(negedge clk);
        check("R1 pins_out", pins_out, 0);
        check("R1 underflow", underflow, 0);
        check("R1 overflow", overflow, 0);
        check("R1 tx_valid", tx_valid, 0);
        rx_valid = 1'b0;
    endtask

    // R2: capture pulses and captured values.
    task automatic t_sampler();
        do_reset();
        pins_in = 8'h11; hist[0] = pins_in;
        for (int c = 0; c < 4*DECIM; c++) begin
            @(negedge clk); k++;
            check("R2 tx_valid", tx_valid, ((k-1) % DECIM) == 0);
            if (((k-1) % DECIM) == 0) check("R2 tx_data", tx_data, hist[k-1]);
            pins_in = 8'(k*13 + 1); hist[k] = pins_in;
        end
    endtask

    // R3/R4: random pins, per-word link delay in [base, base+DECIM-1].
    task automatic t_jitter(input int base, input int cycles);
        logic [PINS-1:0] exp;
        int e, r, d;
        do_reset();
        pins_in = PINS'($urandom); hist[0] = pins_in;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk); k++;
            e = k - 1;
            if (e < LATENCY) exp = '0;
            else begin
                r = LATENCY + ((e - LATENCY) / DECIM) * DECIM;
                exp = hist[r - LATENCY];
            end
            check(e < LATENCY ? "R3 zero before first release" : "R4 delayed pins", pins_out, exp);
            if (tx_valid) begin
                d = base + int'($urandom_range(DECIM-1, 0));
                slot_v[(k+d) % 64] = 1'b1;
                slot_d[(k+d) % 64] = tx_data;
            end
            rx_valid = slot_v[k % 64];
            rx_data  = slot_v[k % 64] ? slot_d[k % 64] : PINS'($urandom);
            slot_v[k % 64] = 1'b0;
            pins_in = PINS'($urandom); hist[k] = pins_in;
        end
        check("R6 no underflow within delay budget", underflow, 0);
        check("R7 no overflow in normal flow", overflow, 0);
        rx_valid = 1'b0;
    endtask

    // R6: delay LATENCY-1 lands each word on its release edge.
    task automatic t_late();
        do_reset();
        pins_in = 8'h5A; hist[0] = pins_in;
        for (int c = 0; c < LATENCY + DECIM + 2; c++) begin
            @(negedge clk); k++;
            if (k == LATENCY + 1) begin
                check("R6 underflow set", underflow, 1);
                check("R6 output held", pins_out, 0);
            end
            if (k == LATENCY + DECIM + 1) begin
                check("R6 sample one period late", pins_out, hist[0]);
                check("R6 underflow sticky", underflow, 1);
            end
            if (tx_valid) begin
                slot_v[(k+LATENCY-1) % 64] = 1'b1;
                slot_d[(k+LATENCY-1) % 64] = tx_data;
            end
            rx_valid = slot_v[k % 64];
            rx_data  = slot_d[k % 64];
            slot_v[k % 64] = 1'b0;
            pins_in = 8'(k*7 + 3); hist[k] = pins_in;
        end
        rx_valid = 1'b0;
    endtask

    // R5/R7/R8/R9: direct writes every edge 0..20, junk with valid low afterwards.
    task automatic t_burst();
        logic [PINS-1:0] v [0:20];
        int m;
        for (int i = 0; i <= 20; i++) v[i] = 8'(i*29 + 7);
        do_reset();
        rx_valid = 1'b1; rx_data = v[0];
        for (int c = 0; c < 70; c++) begin
            @(negedge clk); k++;
            if (k == 8) check("R7 no overflow before full", overflow, 0);
            if (k == 9) check("R7 overflow on drop", overflow, 1);
            if (k >= 21 && ((k - 21) % 4) == 0) begin
                m = (k - 21) / 4;
                if (m < 8)       check("R9 order", pins_out, v[m]);
                else if (m == 8) check("R8 push at full with release", pins_out, v[20]);
                else             check("R5 junk not written", pins_out, v[20]);
                if (m == 8) check("R6 no underflow yet", underflow, 0);
                if (m == 9) check("R6 underflow after drain", underflow, 1);
            end
            if (k <= 20) begin rx_valid = 1'b1; rx_data = v[k]; end
            else begin rx_valid = 1'b0; rx_data = 8'(k*53 + 1); end
        end
        check("R7 overflow sticky", overflow, 1);
    endtask

    initial begin
        t_reset();
        t_sampler();
        t_jitter(0, 200);
        t_jitter(LATENCY - 2 - (DECIM - 1), 200);
        t_late();
        t_burst();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule